// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Aligner

This block sits between a data port that moves 8-byte words and a 64-bit register file. On the load side it takes the memory word, the byte offset of the access inside that word, the access size and a byte-order control bit. It returns the selected bytes right-justified and zero-extended in a 64-bit result. That result is registered and comes out with a valid flag one clock later. On the store side, the same offset, size and byte-order inputs turn register data into byte-lane data and a byte-enable mask. This path is purely combinational, so it can feed a write port in the same cycle.

Accesses of 1, 2, 4 and 8 bytes are supported. With the order bit low, the byte at the lowest address lands in the least-significant byte of the value. With the order bit high, the byte at the lowest address lands in the most-significant byte of the value. A single-byte access reads and writes identically in both orders.

An access whose offset is not a multiple of its size raises an alignment flag. The data is still formed, using lanes that wrap around within the word.

Top module: `ldst_aligner`

## Requirements
- R1: With `big_endian_i` = 0, load byte i of the result (i = 0 is the least-significant byte) equals word lane (offset + i) mod 8, for i below the size in bytes. Word lane j is bits 8j+7:8j. Size code 0/1/2/3 means 1/2/4/8 bytes.
- R2: With `big_endian_i` = 1 and size n, result byte n-1-i equals word lane (offset + i) mod 8, for i below n.
- R3: Every result bit at or above 8×n is zero.
- R4: For a one-byte access (size code 0), the load result, the store lanes and the byte enables are the same for both values of `big_endian_i`.
- R5: Stores follow the same byte-order rule as loads. Lane (offset + i) mod 8 receives register byte i when the order bit is 0, and register byte n-1-i when it is 1. Lanes that are not enabled carry zero.
- R6: `st_byte_en_o` has exactly n bits set: bits (offset + i) mod 8 for i below n.
- R7: `align_err_o` is 1 exactly when the offset is not a multiple of n. `ld_align_err_o` is the registered copy of that flag for the load.
- R8: A misaligned access still produces data and enables from the lanes that wrap modulo 8, as stated in R1, R2, R5 and R6.
- R9: `ld_valid_o` equals `ld_valid_i` from the previous cycle. The load result and its flag update only when `ld_valid_i` is 1 and otherwise hold their values.
- R10: While `rst` is high, the registered outputs `ld_valid_o`, `ld_data_o` and `ld_align_err_o` clear to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Load request this cycle |
| ld_word_i | input | 64 | Memory word for the load |
| st_data_i | input | 64 | Register data for the store |
| acc_offset_i | input | 3 | Byte offset inside the word |
| acc_size_i | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| big_endian_i | input | 1 | Byte order for multi-byte accesses |
| align_err_o | output | 1 | Current access is misaligned (combinational) |
| st_lane_data_o | output | 64 | Store data placed in byte lanes |
| st_byte_en_o | output | 8 | Store byte enables |
| ld_valid_o | output | 1 | Registered load result is valid |
| ld_data_o | output | 64 | Right-justified, zero-extended load result |
| ld_align_err_o | output | 1 | Alignment flag registered with the load |

## Verification
The store lanes, the byte enables and `align_err_o` are due in the same cycle as the inputs. The bench therefore samples them one time unit after driving, well before the next rising edge. The load result, its valid flag and its registered alignment flag are due one rising edge after the request. They are sampled one time unit after that edge, while the inputs are still held steady. A separate step drops `ld_valid_i`, changes the word and checks one edge later that the registered outputs kept their values.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int WORD_BYTES = 8;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int SZ_W       = $clog2(OFF_W + 1);

    typedef enum logic [SZ_W-1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef logic [OFF_W-1:0] lane_idx_t;
    typedef logic [OFF_W:0]   byte_cnt_t;

    typedef struct packed {
        logic      en;
        lane_idx_t reg_byte;
    } lane_route_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              misalign;
    } ld_result_t;

    function automatic byte_cnt_t size_bytes(acc_size_e s);
        return byte_cnt_t'(1) << s;
    endfunction

    function automatic logic is_misaligned(lane_idx_t off, acc_size_e s);
        byte_cnt_t m;
        m = size_bytes(s) - byte_cnt_t'(1);
        return (off & m[OFF_W-1:0]) != '0;
    endfunction
endpackage

// File: rtl/ldst_lane_map.sv
module ldst_lane_map
    import ldst_pkg::*;
(
    input  lane_idx_t                     off_i,
    input  acc_size_e                     size_i,
    input  logic                          big_i,
    output lane_route_t [WORD_BYTES-1:0]  route_o
);
    byte_cnt_t nbytes;
    byte_cnt_t last_idx;

    always_comb begin
        nbytes   = size_bytes(size_i);
        last_idx = nbytes - byte_cnt_t'(1);
    end

    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
        lane_idx_t rel;
        always_comb begin
            rel                  = lane_idx_t'(j) - off_i;
            route_o[j].en        = {1'b0, rel} < nbytes;
            route_o[j].reg_byte  = big_i ? (last_idx[OFF_W-1:0] - rel) : rel;
        end
    end
endmodule

// File: rtl/ldst_ld_extract.sv
module ldst_ld_extract
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0]             word_i,
    input  lane_route_t [WORD_BYTES-1:0]  route_i,
    output logic [WORD_W-1:0]             data_o
);
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_res
        logic [BYTE_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int j = 0; j < WORD_BYTES; j++) begin
                if (route_i[j].en && (route_i[j].reg_byte == lane_idx_t'(k)))
                    acc = acc | word_i[j*BYTE_W +: BYTE_W];
            end
        end
        assign data_o[k*BYTE_W +: BYTE_W] = acc;
    end
endmodule

// File: rtl/ldst_st_merge.sv
module ldst_st_merge
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0]             data_i,
    input  lane_route_t [WORD_BYTES-1:0]  route_i,
    output logic [WORD_W-1:0]             lanes_o,
    output logic [WORD_BYTES-1:0]         ben_o
);
    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
        always_comb begin
            ben_o[j] = route_i[j].en;
            lanes_o[j*BYTE_W +: BYTE_W] = route_i[j].en
                ? data_i[route_i[j].reg_byte*BYTE_W +: BYTE_W]
                : '0;
        end
    end
endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
    import ldst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_valid_i,
    input  logic [63:0] ld_word_i,
    input  logic [63:0] st_data_i,
    input  logic [2:0]  acc_offset_i,
    input  logic [1:0]  acc_size_i,
    input  logic        big_endian_i,
    output logic        align_err_o,
    output logic [63:0] st_lane_data_o,
    output logic [7:0]  st_byte_en_o,
    output logic        ld_valid_o,
    output logic [63:0] ld_data_o,
    output logic        ld_align_err_o
);
    acc_size_e                    size;
    lane_route_t [WORD_BYTES-1:0] route;
    logic [WORD_W-1:0]            ld_comb;
    ld_result_t                   ld_q;

    assign size        = acc_size_e'(acc_size_i);
    assign align_err_o = is_misaligned(acc_offset_i, size);

    ldst_lane_map u_map (
        .off_i   (acc_offset_i),
        .size_i  (size),
        .big_i   (big_endian_i),
        .route_o (route)
    );

    ldst_ld_extract u_ld (
        .word_i  (ld_word_i),
        .route_i (route),
        .data_o  (ld_comb)
    );

    ldst_st_merge u_st (
        .data_i  (st_data_i),
        .route_i (route),
        .lanes_o (st_lane_data_o),
        .ben_o   (st_byte_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q <= '0;
        end else begin
            ld_q.valid <= ld_valid_i;
            if (ld_valid_i) begin
                ld_q.data     <= ld_comb;
                ld_q.misalign <= align_err_o;
            end
        end
    end

    assign ld_valid_o     = ld_q.valid;
    assign ld_data_o      = ld_q.data;
    assign ld_align_err_o = ld_q.misalign;
endmodule

// File: rtl/ldst_aligner_chk.sv
module ldst_aligner_chk (
    input logic        clk,
    input logic        rst,
    input logic        ld_valid_i,
    input logic [2:0]  acc_offset_i,
    input logic [1:0]  acc_size_i,
    input logic        align_err_o,
    input logic [63:0] st_lane_data_o,
    input logic [7:0]  st_byte_en_o,
    input logic        ld_valid_o,
    input logic [63:0] ld_data_o,
    input logic        ld_align_err_o
);
    logic [63:0] en_bits;
    for (genvar j = 0; j < 8; j++) begin : g_exp
        assign en_bits[j*8 +: 8] = {8{st_byte_en_o[j]}};
    end

    assert_ben_count_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(st_byte_en_o) == (32'd1 << acc_size_i));

    assert_ben_start_R6: assert property (@(posedge clk) disable iff (rst)
        st_byte_en_o[acc_offset_i]);

    assert_idle_lanes_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (st_lane_data_o & ~en_bits) == 64'd0);

    assert_byte_never_misaligned_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_size_i == 2'd0) |-> !align_err_o);

    assert_aligned_offset_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_offset_i == 3'd0) |-> !align_err_o);

    assert_flag_registered_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_valid_i)) |-> ld_align_err_o == $past(align_err_o));

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ld_valid_o == $past(ld_valid_i));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ld_valid_i)) |-> $stable(ld_data_o));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_valid_i)) |->
            (ld_data_o >> (7'd8 << $past(acc_size_i))) == 64'd0);
endmodule

bind ldst_aligner ldst_aligner_chk u_chk (.*);

// File: tb/ldst_aligner_bench.sv
module ldst_aligner_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid_i;
    logic [63:0] ld_word_i;
    logic [63:0] st_data_i;
    logic [2:0]  acc_offset_i;
    logic [1:0]  acc_size_i;
    logic        big_endian_i;
    logic        align_err_o;
    logic [63:0] st_lane_data_o;
    logic [7:0]  st_byte_en_o;
    logic        ld_valid_o;
    logic [63:0] ld_data_o;
    logic        ld_align_err_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ldst_aligner u_ldst_aligner (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(input int p, input int salt);
        logic [63:0] w;
        for (int b = 0; b < 8; b++)
            w[b*8 +: 8] = 8'((b + 1) * 8'h11) ^ 8'(p * 8'h5a) ^ 8'(salt);
        return w;
    endfunction

    task automatic run_one(input int off, input int sz, input bit be, input int p);
        int          n;
        int          lane;
        int          k;
        logic [63:0] w, d, exp_ld, exp_st;
        logic [7:0]  exp_en;
        bit          exp_mis;
        string       tag;
        n = 1 << sz;
        w = mk_word(p, 8'h00);
        d = mk_word(p + 3, 8'hc3);
        exp_ld = '0; exp_st = '0; exp_en = '0;
        for (int i = 0; i < n; i++) begin
            lane = (off + i) % 8;
            k    = be ? (n - 1 - i) : i;
            exp_ld[k*8 +: 8]    = w[lane*8 +: 8];
            exp_st[lane*8 +: 8] = d[k*8 +: 8];
            exp_en[lane]        = 1'b1;
        end
        exp_mis = (off % n) != 0;
        if (sz == 0)      tag = "R4";
        else if (exp_mis) tag = "R8";
        else if (be)      tag = "R2";
        else              tag = "R1";

        @(negedge clk);
        ld_valid_i = 1'b1; ld_word_i = w; st_data_i = d;
        acc_offset_i = 3'(off); acc_size_i = 2'(sz); big_endian_i = be;
        #1;
        check(st_lane_data_o === exp_st, {tag, "/R5 store lanes"}, st_lane_data_o, exp_st);
        check(st_byte_en_o === exp_en, {tag, "/R6 byte enables"},
              64'(st_byte_en_o), 64'(exp_en));
        check(align_err_o === exp_mis, "R7 align flag", 64'(align_err_o), 64'(exp_mis));
        @(posedge clk);
        #1;
        check(ld_valid_o === 1'b1, "R9 valid", 64'(ld_valid_o), 64'd1);
        check(ld_data_o === exp_ld, {tag, "/R3 load data"}, ld_data_o, exp_ld);
        check(ld_align_err_o === exp_mis, "R7 registered flag",
              64'(ld_align_err_o), 64'(exp_mis));
    endtask

    initial begin
        logic [63:0] held;
        rst = 1'b1; ld_valid_i = 1'b1; ld_word_i = '1; st_data_i = '0;
        acc_offset_i = 3'd1; acc_size_i = 2'd1; big_endian_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(ld_valid_o === 1'b0, "R10 reset valid", 64'(ld_valid_o), 64'd0);
        check(ld_data_o === 64'd0, "R10 reset data", ld_data_o, 64'd0);
        check(ld_align_err_o === 1'b0, "R10 reset flag", 64'(ld_align_err_o), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int p = 0; p < 3; p++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 8; off++)
                    for (int be = 0; be < 2; be++)
                        run_one(off, sz, be[0], p);

        held = ld_data_o;
        @(negedge clk);
        ld_valid_i = 1'b0; ld_word_i = 64'h0123_4567_89ab_cdef;
        acc_offset_i = 3'd0; acc_size_i = 2'd3;
        @(posedge clk);
        #1;
        check(ld_valid_o === 1'b0, "R9 idle valid", 64'(ld_valid_o), 64'd0);
        check(ld_data_o === held, "R9 idle hold", ld_data_o, held);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule